// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block holds the operational registers of a central processor: eight 18-bit address registers (A0..A7), eight 18-bit index registers (B0..B7) and eight 60-bit data registers (X0..X7). Address register An is paired with data register Xn. Putting an address into A1..A5 starts a memory read whose returned word lands in the paired data register. Putting an address into A6 or A7 starts a memory write of the paired data register to that address. A0 and all index registers are plain storage and never touch memory.

The block has one register write port, one combinational register read port and one memory request channel. The request channel is valid/ready. Once `mem_req_valid` rises, the request and its address, direction and write data stay unchanged until the cycle in which `mem_req_ready` is high. Read data comes back on a separate response strobe, and no ready signal goes with it. Only one memory operation is in flight at a time. While an operation is pending, `wr_ready` is low and the block applies back-pressure: the write port ignores any write to A1..A7. Every other write is still accepted.

Top module: `arf_top`

## Requirements
- R1: After reset every A, B and X register reads zero, `wr_ready` is high and `mem_req_valid` is low.
- R2: Bank code 0 selects A, 1 selects B, 2 selects X, and code 3 is ignored on write and reads zero. A and B writes keep `wr_data[17:0]`. A and B reads are zero-extended to 60 bits. X writes keep all 60 bits. A read returns the value present before the current cycle's write.
- R3: A write to A0 updates only A0. It is accepted even while `wr_ready` is low, and it never raises a request or changes X0.
- R4: An accepted write to A1..A5 raises `mem_req_valid` in the next cycle, with `mem_req_write` low and `mem_req_addr` equal to the written address. The paired X register takes `mem_rsp_data` at the clock edge on which `mem_rsp_valid` is high while that load waits for its response.
- R5: An accepted write to A6 or A7 raises `mem_req_valid` in the next cycle, with `mem_req_write` high and `mem_req_wdata` equal to the paired X register as it was in the cycle of the A write. Later writes to that X register do not alter the request.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request and all its fields stay unchanged. A store completes on the handshake edge. A load then waits for its response.
- R7: `wr_ready` is low from the cycle after an A1..A7 write is accepted until the cycle after the operation completes. A1..A7 writes made while it is low change no register and start no request.
- R8: While a load is pending, reading its target X register returns the old value and raises `rd_busy`. `rd_busy` is low for every other read.
- R9: `mem_rsp_valid` is ignored unless a load has completed its request handshake and is waiting for data.
- R10: If a load response and a write-port write target the same X register in one cycle, the response data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Write bank: 0 A, 1 B, 2 X |
| wr_idx | input | 3 | Register index within bank |
| wr_data | input | 60 | Write data; A/B use bits 17:0 |
| wr_ready | output | 1 | High when no memory operation is pending |
| rd_bank | input | 2 | Read bank code |
| rd_idx | input | 3 | Read register index |
| rd_data | output | 60 | Selected register value |
| rd_busy | output | 1 | Read targets the X register of a pending load |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_addr | output | 18 | Memory word address |
| mem_req_wdata | output | 60 | Store data |
| mem_rsp_valid | input | 1 | Load data strobe |
| mem_rsp_data | input | 60 | Load data |

## Verification
A wrong sequencer state shows at the ports in the very next cycle. It appears as a `wr_ready` level that does not match the pending operation, or as a request that is dropped, duplicated or changed while it is stalled. A load that writes the wrong data register, or a store that samples X too late, stays hidden until that register is read back or the request data is compared. For this reason the bench checks the read port and the request fields in every cycle against a cycle-accurate reference model. A stray response accepted outside the wait state corrupts an X register silently. It is caught only when that register is read.

// File: rtl/arf_pkg.sv
package arf_pkg;
  localparam int NREG = 8;
  localparam int AW   = 18;
  localparam int DW   = 60;
  localparam int IW   = $clog2(NREG);

  localparam logic [1:0] BK_ADR = 2'd0;
  localparam logic [1:0] BK_IDX = 2'd1;
  localparam logic [1:0] BK_DAT = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/arf_bank.sv
module arf_bank #(
  parameter int W  = 60,
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_a,
  input  logic [IW-1:0]        idx_a,
  input  logic [W-1:0]         dat_a,
  input  logic                 we_b,
  input  logic [IW-1:0]        idx_b,
  input  logic [W-1:0]         dat_b,
  output logic [N-1:0][W-1:0]  q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                q[i] <= '0;
      else if (we_b && idx_b == IW'(i))          q[i] <= dat_b;
      else if (we_a && idx_a == IW'(i))          q[i] <= dat_a;
    end
  end

  // R10: port b (load return) wins a same-register collision
  a_r10_port_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b && idx_a == idx_b) |=> q[$past(idx_b)] == $past(dat_b));
endmodule

// File: rtl/arf_memseq.sv
module arf_memseq
  import arf_pkg::*;
#(
  parameter int AWD = 18,
  parameter int DWD = 60,
  parameter int IWD = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_store,
  input  logic [IWD-1:0]  start_idx,
  input  logic [AWD-1:0]  start_addr,
  input  logic [DWD-1:0]  start_wdata,
  output logic            idle,
  output logic            load_pend,
  output logic [IWD-1:0]  load_idx,
  output logic            ld_we,
  output logic [DWD-1:0]  ld_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AWD-1:0]  mem_req_addr,
  output logic [DWD-1:0]  mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [DWD-1:0]  mem_rsp_data
);
  seq_state_e st;
  logic           op_store;
  logic [IWD-1:0] op_idx;
  logic [AWD-1:0] op_addr;
  logic [DWD-1:0] op_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      op_store <= 1'b0;
      op_idx   <= '0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          st       <= SQ_REQ;
          op_store <= start_store;
          op_idx   <= start_idx;
          op_addr  <= start_addr;
          op_wdata <= start_wdata;
        end
        SQ_REQ:  if (mem_req_ready) st <= op_store ? SQ_IDLE : SQ_WAIT;
        SQ_WAIT: if (mem_rsp_valid) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign idle          = (st == SQ_IDLE);
  assign load_pend     = (st != SQ_IDLE) && !op_store;
  assign load_idx      = op_idx;
  assign ld_we         = (st == SQ_WAIT) && mem_rsp_valid;
  assign ld_data       = mem_rsp_data;
  assign mem_req_valid = (st == SQ_REQ);
  assign mem_req_write = op_store;
  assign mem_req_addr  = op_addr;
  assign mem_req_wdata = op_wdata;

  // R6: a stalled request holds every field
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));
  // R6: a store handshake frees the sequencer at once
  a_r6_store_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> idle);
  // R9: a response outside the wait state writes nothing
  a_r9_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && (idle || mem_req_valid)) |-> !ld_we);
endmodule

// File: rtl/arf_top.sv
module arf_top
  import arf_pkg::*;
#(
  parameter int LOAD_LAST = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_bank,
  input  logic [IW-1:0]  wr_idx,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_ready,
  input  logic [1:0]     rd_bank,
  input  logic [IW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic           rd_busy,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DW-1:0]  mem_req_wdata,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data
);
  logic [NREG-1:0][AW-1:0] a_q;
  logic [NREG-1:0][AW-1:0] b_q;
  logic [NREG-1:0][DW-1:0] x_q;

  logic          idle, load_pend, ld_we;
  logic [IW-1:0] load_idx;
  logic [DW-1:0] ld_data;
  logic          a_sel, a_side, start, a_we;
  logic [DW-1:0] st_sample;

  assign a_sel     = wr_en && (wr_bank == BK_ADR);
  assign a_side    = a_sel && (wr_idx != '0);
  assign start     = a_side && idle;
  assign a_we      = a_sel && ((wr_idx == '0) || idle);
  assign st_sample = x_q[wr_idx];

  arf_bank #(.W(AW), .N(NREG)) u_abank (
    .clk(clk), .rst_n(rst_n),
    .we_a(a_we), .idx_a(wr_idx), .dat_a(wr_data[AW-1:0]),
    .we_b(1'b0), .idx_b('0), .dat_b('0),
    .q(a_q));

  arf_bank #(.W(AW), .N(NREG)) u_bbank (
    .clk(clk), .rst_n(rst_n),
    .we_a(wr_en && (wr_bank == BK_IDX)), .idx_a(wr_idx), .dat_a(wr_data[AW-1:0]),
    .we_b(1'b0), .idx_b('0), .dat_b('0),
    .q(b_q));

  arf_bank #(.W(DW), .N(NREG)) u_xbank (
    .clk(clk), .rst_n(rst_n),
    .we_a(wr_en && (wr_bank == BK_DAT)), .idx_a(wr_idx), .dat_a(wr_data),
    .we_b(ld_we), .idx_b(load_idx), .dat_b(ld_data),
    .q(x_q));

  arf_memseq #(.AWD(AW), .DWD(DW), .IWD(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_store(wr_idx > IW'(LOAD_LAST)), .start_idx(wr_idx),
    .start_addr(wr_data[AW-1:0]), .start_wdata(st_sample),
    .idle(idle), .load_pend(load_pend), .load_idx(load_idx),
    .ld_we(ld_we), .ld_data(ld_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  assign wr_ready = idle;

  always_comb begin
    unique case (rd_bank)
      BK_ADR:  rd_data = DW'(a_q[rd_idx]);
      BK_IDX:  rd_data = DW'(b_q[rd_idx]);
      BK_DAT:  rd_data = x_q[rd_idx];
      default: rd_data = '0;
    endcase
  end
  assign rd_busy = load_pend && (rd_bank == BK_DAT) && (rd_idx == load_idx);

  // R3: A0 is quiet storage
  a_r3_a0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && wr_idx == '0 && wr_ready) |=> !mem_req_valid && x_q == $past(x_q));
  // R4: A1..A5 issues a read at the written address
  a_r4_load_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_idx <= IW'(LOAD_LAST)) |=> mem_req_valid && !mem_req_write
      && mem_req_addr == $past(wr_data[AW-1:0]));
  // R5: A6/A7 stores the X value seen at the A write
  a_r5_store_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_idx > IW'(LOAD_LAST)) |=> mem_req_valid && mem_req_write
      && mem_req_wdata == $past(st_sample));
  // R7: side-effect writes while busy change no A register
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (a_side && !wr_ready) |=> a_q == $past(a_q));
  // R8: busy flag only on the X bank
  a_r8_busy_bank: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> (rd_bank == BK_DAT) && !wr_ready);
endmodule

// File: tb/arf_top_test.sv
module arf_top_test;
  import arf_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_bank = '0;
  logic [2:0] wr_idx = '0;
  logic [59:0] wr_data = '0;
  logic wr_ready;
  logic [1:0] rd_bank = '0;
  logic [2:0] rd_idx = '0;
  logic [59:0] rd_data;
  logic rd_busy;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [17:0] mem_req_addr;
  logic [59:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [59:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  arf_top uut (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [17:0] ma [8];
  logic [17:0] mb [8];
  logic [59:0] mx [8];
  int          pend = 0;      // 0 idle, 1 request, 2 waiting for data
  int          pend_prev = 0;
  bit          p_store;
  int          p_idx;
  logic [17:0] p_addr;
  logic [59:0] p_wdata;
  string       rd_tag = "";

  function automatic logic [59:0] model_read(input logic [1:0] bk, input logic [2:0] ix);
    case (bk)
      2'd0: return 60'(ma[ix]);
      2'd1: return 60'(mb[ix]);
      2'd2: return mx[ix];
      default: return '0;
    endcase
  endfunction

  function automatic logic [59:0] mem_word(input logic [17:0] ad);
    return (60'(ad) * 60'h9E3779B97) ^ 60'hC0FFEE123456;
  endfunction

  task automatic chk(input string tag, input logic [59:0] act, input logic [59:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit we, input logic [1:0] wb, input logic [2:0] wi,
                      input logic [59:0] wd, input logic [1:0] rb, input logic [2:0] ri,
                      input bit rdy, input bit rv, input logic [59:0] rdat);
    string mtag;
    int npend;
    wr_en = we; wr_bank = wb; wr_idx = wi; wr_data = wd;
    rd_bank = rb; rd_idx = ri;
    mem_req_ready = rdy; mem_rsp_valid = rv; mem_rsp_data = rdat;
    #2;
    chk("R7 wr_ready", 60'(wr_ready), 60'(pend == 0));
    mtag = (pend == 1 && pend_prev == 1) ? "R6" : (p_store ? "R5" : "R4");
    chk({mtag, " req_valid"}, 60'(mem_req_valid), 60'(pend == 1));
    if (pend == 1) begin
      chk({mtag, " req_write"}, 60'(mem_req_write), 60'(p_store));
      chk({mtag, " req_addr"}, 60'(mem_req_addr), 60'(p_addr));
      if (p_store) chk({mtag, " req_wdata"}, mem_req_wdata, p_wdata);
    end
    begin
      bit exp_busy;
      exp_busy = (pend != 0) && !p_store && rb == 2'd2 && int'(ri) == p_idx;
      chk("R8 rd_busy", 60'(rd_busy), 60'(exp_busy));
      chk(rd_tag != "" ? rd_tag : (exp_busy ? "R8 rd_data" : "R2 rd_data"),
          rd_data, model_read(rb, ri));
    end
    @(posedge clk);
    cyc++;
    npend = pend;
    if (pend == 1 && rdy) npend = p_store ? 0 : 2;
    if (we) begin
      case (wb)
        2'd0: if (wi == 3'd0) ma[0] = wd[17:0];
              else if (pend == 0) begin
                ma[wi] = wd[17:0];
                npend = 1; p_store = (wi >= 3'd6); p_idx = int'(wi);
                p_addr = wd[17:0]; p_wdata = mx[wi];
              end
        2'd1: mb[wi] = wd[17:0];
        2'd2: mx[wi] = wd;
        default: ;
      endcase
    end
    if (pend == 2 && rv) begin
      mx[p_idx] = rdat;
      npend = 0;
    end
    pend_prev = pend;
    pend = npend;
    @(negedge clk);
  endtask

  task automatic idle_step(input logic [1:0] rb, input logic [2:0] ri, input bit rdy,
                           input bit rv, input logic [59:0] rdat);
    step(1'b0, 2'd0, 3'd0, '0, rb, ri, rdy, rv, rdat);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin ma[i] = '0; mb[i] = '0; mx[i] = '0; end
    p_store = 0; p_idx = 0; p_addr = '0; p_wdata = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents of all 24 registers and idle memory side
    rd_tag = "R1 reset read";
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 8; i++) idle_step(2'(b), 3'(i), 1'b0, 1'b0, '0);
    rd_tag = "";
    // R2: truncation, zero-extension, bank 3 ignored
    step(1'b1, 2'd1, 3'd2, 60'hFFFF_FFFF_FFFF_FFF, 2'd1, 3'd2, 0, 0, '0);
    step(1'b1, 2'd3, 3'd2, 60'h123, 2'd1, 3'd2, 0, 0, '0);
    idle_step(2'd3, 3'd2, 0, 0, '0);
    // R3: A0 write has no memory effect
    step(1'b1, 2'd2, 3'd0, 60'hABC, 2'd2, 3'd0, 0, 0, '0);
    step(1'b1, 2'd0, 3'd0, 60'h3_1234, 2'd0, 3'd0, 1, 0, '0);
    rd_tag = "R3 A0 read"; idle_step(2'd0, 3'd0, 1, 0, '0);
    rd_tag = "R3 X0 kept"; idle_step(2'd2, 3'd0, 1, 0, '0); rd_tag = "";
    // R5/R6: store samples X6, then X6 rewritten while stalled
    step(1'b1, 2'd2, 3'd6, 60'h0DEA_DBEE_F000_111, 2'd2, 3'd6, 0, 0, '0);
    step(1'b1, 2'd0, 3'd6, 60'h0_0F00, 2'd2, 3'd6, 0, 0, '0);
    step(1'b1, 2'd2, 3'd6, 60'h5555, 2'd2, 3'd6, 0, 0, '0);
    // R3: A0 accepted while busy
    step(1'b1, 2'd0, 3'd0, 60'h7, 2'd0, 3'd0, 0, 0, '0);
    idle_step(2'd0, 3'd0, 1, 0, '0);
    // R4/R8/R7: load into X3, busy read, blocked A4 write
    step(1'b1, 2'd0, 3'd3, 60'h0_0420, 2'd2, 3'd3, 0, 0, '0);
    step(1'b1, 2'd0, 3'd4, 60'h0_0999, 2'd2, 3'd3, 1, 0, '0);
    rd_tag = "R7 A4 unchanged"; idle_step(2'd0, 3'd4, 0, 0, '0); rd_tag = "";
    // R10: response collides with X3 write
    step(1'b1, 2'd2, 3'd3, 60'h1111, 2'd2, 3'd3, 0, 1, mem_word(18'h420));
    rd_tag = "R10 X3 load wins"; idle_step(2'd2, 3'd3, 0, 0, '0);
    // R9: stray response while idle
    idle_step(2'd2, 3'd5, 0, 1, 60'hBAD);
    rd_tag = "R9 X5 untouched"; idle_step(2'd2, 3'd5, 0, 0, '0); rd_tag = "";
    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit we, rdy, rv;
      logic [1:0] wb, rb;
      logic [2:0] wi, ri;
      logic [59:0] wd;
      we = ($urandom % 3) != 0;
      wb = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      wi = 3'($urandom);
      wd = {28'($urandom), 32'($urandom)};
      rb = 2'($urandom % 3);
      ri = 3'($urandom);
      if (pend != 0 && !p_store && ($urandom % 2 == 0)) begin rb = 2'd2; ri = 3'(p_idx); end
      rdy = ($urandom % 2) == 0;
      rv  = (pend == 2) ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
      step(we, wb, wi, wd, rb, ri, rdy, rv,
           (pend == 2) ? mem_word(p_addr) : {28'($urandom), 32'($urandom)});
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule